// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block turns a serial stream of data bits into a serial stream of coded bits. Each accepted data bit goes through a rate-1/2 convolutional code with constraint length 7, which has a six-bit memory and two parity branches. The first branch uses generator 133 (octal) and the second uses 171 (octal). A puncturing stage then removes some of the coded bits in a fixed repeating pattern. This gives a final code rate of 1/2, 2/3 or 3/4.

A frame begins with a one-cycle start strobe. The strobe clears the code memory and the puncturing phase, and it also captures the rate select for the whole frame. Data bits follow, each marked by a data-valid pulse. The two coded bits of one data bit leave on consecutive cycles: branch A first, then branch B. A dropped bit takes its cycle as a gap with the valid flag low. The upstream logic must space data-valid pulses at least two cycles apart and must supply its own zero tail bits.

Top module: `convPunctEncoder`

## Requirements
- R1: After reset, codeValid and codeOut are 0, the code memory is all zero, and the rate is 1/2 until the first start strobe.
- R2: The branch-A bit is the XOR of the current data bit and the memory taps selected by 133 octal. Bit 6 of the generator is the current bit and bit 0 is the oldest stored bit, so A = d ^ s2 ^ s3 ^ s5 ^ s6, where s1 is the previous input.
- R3: The branch-B bit uses generator 171 octal in the same way: B = d ^ s1 ^ s2 ^ s3 ^ s6.
- R4: A data bit accepted at a clock edge presents its A slot in the next cycle and its B slot in the cycle after that. codeValid is never high without an accepted data bit in one of the two cycles before it.
- R5: Rate select 0 (and the spare code 3) selects rate 1/2: both slots of every data bit are sent.
- R6: Rate select 1 selects rate 2/3 over a two-bit cycle: A0, B0 and A1 are sent, and B1 is dropped.
- R7: Rate select 2 selects rate 3/4 over a three-bit cycle: A0, B0, A1 and B2 are sent, and B1 and A2 are dropped.
- R8: The start strobe clears the code memory, the puncturing phase and any pending output slot. codeValid is low in the cycle after start, and a data bit offered in the start cycle is ignored.
- R9: Rate select is captured only with the start strobe. Changing it within a frame has no effect.
- R10: With no data bit, the memory and phase hold. In every cycle where codeValid is low, codeOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame start strobe; clears state and captures rateSel |
| dataIn | input | 1 | Serial data bit |
| dataValid | input | 1 | dataIn is valid this cycle |
| rateSel | input | 2 | 0: rate 1/2, 1: rate 2/3, 2: rate 3/4, 3: rate 1/2 |
| codeOut | output | 1 | Serial coded bit |
| codeValid | output | 1 | codeOut carries a kept coded bit |

## Verification
A corrupted bit in the code memory appears in codeOut within the next one to six data bits. It persists until the bad bit has shifted out, so every bit of each frame is compared against an independent encoder model. A puncturing phase that is off by one moves the valid gaps to the wrong slot. A wrong rate latch changes the gap spacing. Both of these show in codeValid within one pattern period, which is at most three data bits. The checks therefore run every rate over frames longer than one period, with idle gaps and mid-frame rate changes.

// File: rtl/pe_pkg.sv
package pe_pkg;

  localparam int PHASE_W = 2;

  typedef enum logic [1:0] {
    RATE_HALF           = 2'd0,
    RATE_TWO_THIRDS     = 2'd1,
    RATE_THREE_QUARTERS = 2'd2,
    RATE_HALF_SPARE     = 2'd3
  } rate_e;

  typedef struct packed {
    logic clearState;
    logic shiftIn;
    logic emitA;
    logic emitB;
    logic keepA;
    logic keepB;
  } ctrlStrobes_t;

  // bit 1: keep branch A, bit 0: keep branch B
  function automatic logic [1:0] peKeep(rate_e r, logic [PHASE_W-1:0] ph);
    logic [1:0] m;
    case (r)
      RATE_TWO_THIRDS:     m = (ph == '0) ? 2'b11 : 2'b10;
      RATE_THREE_QUARTERS: begin
        case (ph)
          2'd0:    m = 2'b11;
          2'd1:    m = 2'b10;
          default: m = 2'b01;
        endcase
      end
      default:             m = 2'b11;
    endcase
    return m;
  endfunction

  function automatic logic [PHASE_W-1:0] peLastPhase(rate_e r);
    logic [PHASE_W-1:0] l;
    case (r)
      RATE_TWO_THIRDS:     l = PHASE_W'(1);
      RATE_THREE_QUARTERS: l = PHASE_W'(2);
      default:             l = '0;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/peParity.sv
module peParity #(
  parameter int CONSTRAINT_LEN = 7,
  parameter logic [CONSTRAINT_LEN-1:0] POLY = 7'o133
) (
  input  logic [CONSTRAINT_LEN-1:0] window,
  output logic                      parity
);
  logic [CONSTRAINT_LEN-1:0] tapped;

  always_comb begin
    tapped = window & POLY;
    parity = ^tapped;
  end
endmodule

// File: rtl/peDatapath.sv
module peDatapath
  import pe_pkg::*;
#(
  parameter int CONSTRAINT_LEN = 7,
  parameter logic [CONSTRAINT_LEN-1:0] GEN_A = 7'o133,
  parameter logic [CONSTRAINT_LEN-1:0] GEN_B = 7'o171
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic         dataIn,
  output logic         codeOut,
  output logic         codeValid
);
  localparam int MEM_LEN    = CONSTRAINT_LEN - 1;
  localparam int NUM_BRANCH = 2;

  // hist[MEM_LEN-1] is the newest stored bit, hist[0] the oldest
  logic [MEM_LEN-1:0]        hist;
  logic [CONSTRAINT_LEN-1:0] window;
  logic [NUM_BRANCH-1:0]     branchBit;
  logic [NUM_BRANCH-1:0]     codeReg;   // bit 1: A, bit 0: B

  assign window = {dataIn, hist};

  for (genvar g = 0; g < NUM_BRANCH; g++) begin : g_branch
    localparam logic [CONSTRAINT_LEN-1:0] POLY = (g == 0) ? GEN_A : GEN_B;
    peParity #(
      .CONSTRAINT_LEN(CONSTRAINT_LEN),
      .POLY          (POLY)
    ) parity_i (
      .window(window),
      .parity(branchBit[NUM_BRANCH-1-g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clearState) begin
      hist    <= '0;
      codeReg <= '0;
    end else if (strobes.shiftIn) begin
      hist    <= {dataIn, hist[MEM_LEN-1:1]};
      codeReg <= branchBit;
    end
  end

  always_comb begin
    codeValid = (strobes.emitA & strobes.keepA) | (strobes.emitB & strobes.keepB);
    codeOut   = codeValid & (strobes.emitA ? codeReg[1] : codeReg[0]);
  end
endmodule

// File: rtl/peControl.sv
module peControl
  import pe_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         dataValid,
  input  logic [1:0]   rateSel,
  output ctrlStrobes_t strobes
);
  rate_e              rateReg;
  logic [PHASE_W-1:0] phase;
  logic               slotA;
  logic               slotB;
  logic               keepAReg;
  logic               keepBReg;
  logic [1:0]         keepNow;
  logic               accept;

  always_comb begin
    keepNow = peKeep(rateReg, phase);
    accept  = dataValid & ~start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rateReg  <= RATE_HALF;
      phase    <= '0;
      slotA    <= 1'b0;
      slotB    <= 1'b0;
      keepAReg <= 1'b0;
      keepBReg <= 1'b0;
    end else if (start) begin
      rateReg  <= rate_e'(rateSel);
      phase    <= '0;
      slotA    <= 1'b0;
      slotB    <= 1'b0;
      keepAReg <= 1'b0;
      keepBReg <= 1'b0;
    end else begin
      slotA <= accept;
      slotB <= slotA;
      if (accept) begin
        keepAReg <= keepNow[1];
        keepBReg <= keepNow[0];
        phase    <= (phase == peLastPhase(rateReg)) ? '0 : phase + PHASE_W'(1);
      end
    end
  end

  always_comb begin
    strobes.clearState = start;
    strobes.shiftIn    = accept;
    strobes.emitA      = slotA;
    strobes.emitB      = slotB & ~slotA;
    strobes.keepA      = keepAReg;
    strobes.keepB      = keepBReg;
  end
endmodule

// File: rtl/convPunctEncoder.sv
module convPunctEncoder
  import pe_pkg::*;
#(
  parameter int CONSTRAINT_LEN = 7,
  parameter logic [CONSTRAINT_LEN-1:0] GEN_A = 7'o133,
  parameter logic [CONSTRAINT_LEN-1:0] GEN_B = 7'o171
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       dataIn,
  input  logic       dataValid,
  input  logic [1:0] rateSel,
  output logic       codeOut,
  output logic       codeValid
);
  ctrlStrobes_t strobes;

  peControl control_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dataValid(dataValid),
    .rateSel  (rateSel),
    .strobes  (strobes)
  );

  peDatapath #(
    .CONSTRAINT_LEN(CONSTRAINT_LEN),
    .GEN_A         (GEN_A),
    .GEN_B         (GEN_B)
  ) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .codeOut  (codeOut),
    .codeValid(codeValid)
  );
endmodule

// File: rtl/puncEncChecker.sv
module puncEncChecker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       dataValid,
  input logic [1:0] rateSel,
  input logic       codeOut,
  input logic       codeValid
);
  logic [1:0] sinceRst;
  logic       chkHalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= 2'd0;
      chkHalf  <= 1'b1;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (start) chkHalf <= (rateSel == 2'd0) || (rateSel == 2'd3);
    end
  end

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !codeValid |-> !codeOut); // R10

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && codeValid) |->
      ($past(dataValid && !start) || $past(dataValid && !start, 2))); // R4

  AST_START_SILENCES: assert property (@(posedge clk) disable iff (rst)
    start |=> !codeValid); // R8

  AST_HALF_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
    (chkHalf && dataValid && !start) |=> codeValid); // R5
endmodule

bind convPunctEncoder puncEncChecker chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .dataValid(dataValid),
  .rateSel  (rateSel),
  .codeOut  (codeOut),
  .codeValid(codeValid)
);

// File: tb/convPunctEncoder_tb_top.sv
module convPunctEncoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       dataIn = 1'b0;
  logic       dataValid = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic       codeOut;
  logic       codeValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // independent model state
  logic       s [1:6];
  int         mRate;   // 0: 1/2, 1: 2/3, 2: 3/4
  int         mPhase;

  always #4 clk = ~clk;

  convPunctEncoder dut_i (
    .clk(clk), .rst(rst), .start(start), .dataIn(dataIn),
    .dataValid(dataValid), .rateSel(rateSel),
    .codeOut(codeOut), .codeValid(codeValid)
  );

  typedef struct packed {
    logic [1:0]  rate;
    logic [4:0]  len;
    logic [15:0] bits;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{rate: 2'd0, len: 5'd7,  bits: 16'h0001},
    '{rate: 2'd1, len: 5'd8,  bits: 16'h00B5},
    '{rate: 2'd2, len: 5'd9,  bits: 16'h0133},
    '{rate: 2'd3, len: 5'd6,  bits: 16'h002D},
    '{rate: 2'd2, len: 5'd12, bits: 16'h0FFF},
    '{rate: 2'd1, len: 5'd7,  bits: 16'h0041}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelClear(input int r);
    for (int i = 1; i <= 6; i++) s[i] = 1'b0;
    mPhase = 0;
    mRate  = (r == 3) ? 0 : r;
  endtask

  function automatic string rateTag(input int r);
    if (r == 1) return "R6";
    if (r == 2) return "R7";
    return "R5";
  endfunction

  task automatic doStart(input int r, input bit withData);
    start = 1'b1; rateSel = 2'(r);
    dataValid = withData; dataIn = 1'b1;
    @(negedge clk);
    start = 1'b0; dataValid = 1'b0; dataIn = 1'b0;
    modelClear(r);
    chk(codeValid == 1'b0, "R8 valid after start", codeValid, 0);
  endtask

  task automatic sendBit(input bit b);
    bit a, bb, kA, kB;
    a  = b ^ s[2] ^ s[3] ^ s[5] ^ s[6];
    bb = b ^ s[1] ^ s[2] ^ s[3] ^ s[6];
    kA = 1'b1; kB = 1'b1;
    if (mRate == 1 && mPhase == 1) kB = 1'b0;
    if (mRate == 2 && mPhase == 1) kB = 1'b0;
    if (mRate == 2 && mPhase == 2) kA = 1'b0;
    for (int i = 6; i >= 2; i--) s[i] = s[i-1];
    s[1] = b;
    mPhase = (mRate == 0) ? 0 : (mPhase + 1) % (mRate + 1);
    dataIn = b; dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
    chk(codeValid == kA, {"R4 ", rateTag(mRate), " A-slot valid"}, codeValid, kA);
    chk(codeOut == (a & kA), "R2 A-slot bit", codeOut, a & kA);
    @(negedge clk);
    chk(codeValid == kB, {"R4 ", rateTag(mRate), " B-slot valid"}, codeValid, kB);
    chk(codeOut == (bb & kB), "R3 B-slot bit", codeOut, bb & kB);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    modelClear(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and default rate, no start issued
    chk(codeValid == 1'b0, "R1 reset valid", codeValid, 0);
    chk(codeOut == 1'b0, "R1 reset bit", codeOut, 0);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      doStart(int'(VECS[v].rate), 1'b0);
      for (int i = 0; i < int'(VECS[v].len); i++) sendBit(VECS[v].bits[i]);
    end

    // R9: rate select changed mid-frame has no effect
    doStart(2, 1'b0);
    sendBit(1'b1); sendBit(1'b1);
    rateSel = 2'd0;
    for (int i = 0; i < 5; i++) sendBit(i[0]);

    // R10: idle cycles hold state and stay silent
    doStart(1, 1'b0);
    sendBit(1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(codeValid == 1'b0, "R10 idle valid", codeValid, 0);
      chk(codeOut == 1'b0, "R10 idle bit", codeOut, 0);
    end
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);

    // R8: start clears memory; data in start cycle ignored
    doStart(0, 1'b0);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    doStart(0, 1'b1);
    for (int i = 0; i < 6; i++) sendBit(1'b0);

    // R8: start during pending B slot drops it
    doStart(0, 1'b0);
    dataIn = 1'b1; dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0; start = 1'b1; rateSel = 2'd2;
    @(negedge clk);
    start = 1'b0;
    modelClear(2);
    chk(codeValid == 1'b0, "R8 pending slot dropped", codeValid, 0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule